// File: doc/BRIEF.md
# ADC Serial Read and Sleep Controller

This block sits on the host side of a three-wire link to a serial-output analog-to-digital converter: an active-low select line, a serial clock that the host drives, and one data line driven by the converter. On command it frames a read: it lowers select, waits a setup time, and then bursts the serial clock while it shifts in a result word, most significant bit first. At the end it raises select, presents the word on a parallel output with a one-cycle valid strobe, and keeps itself busy for a short turnaround gap. Every time interval comes from nanosecond parameters and the system clock rate, rounded up to whole system cycles.

The serial clock line also controls the converter's power. A long high level puts the converter to sleep and a long low level wakes it. The controller therefore keeps the clock low whenever it rests awake. On command it holds the clock high long enough to be sure of sleep entry, and it can hold the clock low for the wake time. A read that arrives while the converter is asleep runs the wake hold first and then the read frame, with no further command. While a sequence runs, a busy output is high and every command is dropped.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, adc_sel_n is 1, adc_ser_clk is 0, busy is 0, data_valid is 0 and data_out is all zeros.
- R2: A start_read seen while idle and awake lowers adc_sel_n in the next cycle. The first rise of adc_ser_clk follows after N_SETUP = ceil(SETUP_NS*CLK_MHZ/1000) cycles with select low. Then exactly WORD_W high phases and WORD_W low phases follow, each N_HALF = ceil(SCLK_HALF_NS*CLK_MHZ/1000) cycles long.
- R3: adc_ser_dat is sampled at the system clock edge where adc_ser_clk goes from 0 to 1. The first sample lands in data_out bit WORD_W-1 and the last in bit 0.
- R4: After the last low phase, adc_sel_n returns to 1 and data_valid is 1 for exactly one cycle, in the first cycle of select high. In that cycle data_out holds the word, and it keeps that value until the next word completes.
- R5: After select rises, busy stays 1 for N_GAP = ceil(GAP_NS*CLK_MHZ/1000) cycles, with select high and the clock low, and then drops to 0.
- R6: An enter_sleep seen while idle and awake keeps busy at 1 for N_SLEEP = ceil(SLEEP_NS*CLK_MHZ/1000) cycles, with adc_ser_clk at 1 and select at 1. Afterwards busy is 0 and adc_ser_clk stays at 1.
- R7: A wake seen while asleep keeps busy at 1 for N_WAKE = ceil(WAKE_NS*CLK_MHZ/1000) cycles, with adc_ser_clk at 0 and select at 1. After that the block is idle and awake, with the clock low.
- R8: A start_read seen while asleep first performs the R7 hold of N_WAKE cycles and then, with no idle cycle between, the complete R2 to R5 read frame.
- R9: Any command that arrives while busy is 1, including in the last busy cycle, has no effect: the current sequence keeps its timing and result, and busy is 0 in the cycle after it ends.
- R10: wake while idle and awake, and enter_sleep while asleep, have no effect: busy stays 0 and adc_ser_clk keeps its level.
- R11: When several commands arrive in the same cycle, start_read wins over enter_sleep, and enter_sleep wins over wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_read | input | 1 | Command: read one result word |
| enter_sleep | input | 1 | Command: put the converter to sleep |
| wake | input | 1 | Command: wake the converter |
| adc_ser_dat | input | 1 | Serial data from the converter |
| adc_sel_n | output | 1 | Active-low converter select |
| adc_ser_clk | output | 1 | Serial clock to the converter, also its power control |
| busy | output | 1 | A sequence is running; commands are ignored |
| data_out | output | WORD_W | Last completed result word |
| data_valid | output | 1 | One-cycle strobe when a word completes |

## Verification
Two things can meet in one cycle. A command can arrive in the very cycle a sequence finishes, and the bench provokes this by driving random command bits on every busy cycle of a frame, the final gap cycle included. Those frames must keep the exact phase lengths and the sent word, and busy must be low in the cycle after. The other meeting is several commands raised together, start_read with enter_sleep, while awake and while asleep, where the read frame must win.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_GAP,
        ST_SLP_HOLD,
        ST_ASLEEP,
        ST_WAKE_HOLD
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_READ,
        CMD_SLEEP,
        CMD_WAKE
    } cmd_e;

    typedef struct packed {
        logic ser_clk;
        logic sel_n;
        logic busy;
    } line_ctrl_t;

    // ceil(ns * mhz / 1000), never below one cycle
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned mhz);
        longint unsigned prod;
        longint unsigned cyc;
        prod = longint'(ns) * longint'(mhz);
        cyc  = (prod + 64'd999) / 64'd1000;
        return (cyc == 0) ? 1 : int'(cyc);
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // fixed priority: read, then sleep, then wake
    function automatic cmd_e pick_cmd(input logic rd, input logic sl, input logic wk);
        if (rd)      return CMD_READ;
        else if (sl) return CMD_SLEEP;
        else if (wk) return CMD_WAKE;
        else         return CMD_NONE;
    endfunction

    function automatic line_ctrl_t drive_lines(input seq_state_e s);
        line_ctrl_t l;
        l = '{ser_clk: 1'b0, sel_n: 1'b1, busy: 1'b0};
        case (s)
            ST_IDLE:      l = '{ser_clk: 1'b0, sel_n: 1'b1, busy: 1'b0};
            ST_SETUP:     l = '{ser_clk: 1'b0, sel_n: 1'b0, busy: 1'b1};
            ST_HIGH:      l = '{ser_clk: 1'b1, sel_n: 1'b0, busy: 1'b1};
            ST_LOW:       l = '{ser_clk: 1'b0, sel_n: 1'b0, busy: 1'b1};
            ST_GAP:       l = '{ser_clk: 1'b0, sel_n: 1'b1, busy: 1'b1};
            ST_SLP_HOLD:  l = '{ser_clk: 1'b1, sel_n: 1'b1, busy: 1'b1};
            ST_ASLEEP:    l = '{ser_clk: 1'b1, sel_n: 1'b1, busy: 1'b0};
            ST_WAKE_HOLD: l = '{ser_clk: 1'b0, sel_n: 1'b1, busy: 1'b1};
            default:      l = '{ser_clk: 1'b0, sel_n: 1'b1, busy: 1'b0};
        endcase
        return l;
    endfunction

endpackage

// File: rtl/adc_phase_timer.sv
`timescale 1ns/1ps
module adc_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [TW-1:0] ld_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (ld)             cnt_q <= ld_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R2 phase lengths rest on a strict one-per-cycle countdown
    p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
        (!ld && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    p_load_lands_r2: assert property (@(posedge clk) disable iff (rst)
        ld |=> (cnt_q == $past(ld_val)));

endmodule

// File: rtl/adc_word_shifter.sv
`timescale 1ns/1ps
module adc_word_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              word_done,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);
    logic [WORD_W-1:0] sr_q;

    generate
        if (WORD_W > 1) begin : g_wide
            always_ff @(posedge clk) begin
                if (rst || clr)    sr_q <= '0;
                else if (shift_en) sr_q <= {sr_q[WORD_W-2:0], bit_in};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst || clr)    sr_q <= '0;
                else if (shift_en) sr_q <= bit_in;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= word_done;
            if (word_done) word_out <= sr_q;
        end
    end

    // R4: output word only moves together with the strobe
    p_word_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !word_valid |-> $stable(word_out));

    p_valid_single_r4: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

endmodule

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
module adc_seq_fsm
    import adc_rd_pkg::*;
#(
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned N_SETUP = 40,
    parameter int unsigned N_HALF  = 50,
    parameter int unsigned N_GAP   = 30,
    parameter int unsigned N_SLEEP = 400,
    parameter int unsigned N_WAKE  = 40,
    parameter int          TW      = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_read,
    input  logic          cmd_sleep,
    input  logic          cmd_wake,
    input  logic          tmr_expired,
    output logic          tmr_ld,
    output logic [TW-1:0] tmr_val,
    output logic          shift_clr,
    output logic          shift_en,
    output logic          word_done,
    output seq_state_e    state
);
    localparam int BW = $clog2(WORD_W + 1);
    localparam logic [TW-1:0] V_SETUP = TW'(N_SETUP - 1);
    localparam logic [TW-1:0] V_HALF  = TW'(N_HALF - 1);
    localparam logic [TW-1:0] V_GAP   = TW'(N_GAP - 1);
    localparam logic [TW-1:0] V_SLEEP = TW'(N_SLEEP - 1);
    localparam logic [TW-1:0] V_WAKE  = TW'(N_WAKE - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W);

    seq_state_e    state_q, state_d;
    logic [BW-1:0] bits_q, bits_d;
    logic          pend_q, pend_d;
    cmd_e          cmd;

    assign cmd   = pick_cmd(cmd_read, cmd_sleep, cmd_wake);
    assign state = state_q;

    always_comb begin
        state_d   = state_q;
        bits_d    = bits_q;
        pend_d    = pend_q;
        tmr_ld    = 1'b0;
        tmr_val   = '0;
        shift_clr = 1'b0;
        shift_en  = 1'b0;
        word_done = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (cmd == CMD_READ) begin
                    state_d   = ST_SETUP;
                    tmr_ld    = 1'b1;
                    tmr_val   = V_SETUP;
                    shift_clr = 1'b1;
                    bits_d    = '0;
                end else if (cmd == CMD_SLEEP) begin
                    state_d = ST_SLP_HOLD;
                    tmr_ld  = 1'b1;
                    tmr_val = V_SLEEP;
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    state_d  = ST_HIGH;
                    tmr_ld   = 1'b1;
                    tmr_val  = V_HALF;
                    shift_en = 1'b1;
                    bits_d   = bits_q + 1'b1;
                end
            end
            ST_HIGH: begin
                if (tmr_expired) begin
                    state_d = ST_LOW;
                    tmr_ld  = 1'b1;
                    tmr_val = V_HALF;
                end
            end
            ST_LOW: begin
                if (tmr_expired) begin
                    if (bits_q == LAST_BIT) begin
                        state_d   = ST_GAP;
                        tmr_ld    = 1'b1;
                        tmr_val   = V_GAP;
                        word_done = 1'b1;
                    end else begin
                        state_d  = ST_HIGH;
                        tmr_ld   = 1'b1;
                        tmr_val  = V_HALF;
                        shift_en = 1'b1;
                        bits_d   = bits_q + 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            ST_SLP_HOLD: begin
                if (tmr_expired) state_d = ST_ASLEEP;
            end
            ST_ASLEEP: begin
                if (cmd == CMD_READ || cmd == CMD_WAKE) begin
                    state_d = ST_WAKE_HOLD;
                    tmr_ld  = 1'b1;
                    tmr_val = V_WAKE;
                    pend_d  = (cmd == CMD_READ);
                end
            end
            ST_WAKE_HOLD: begin
                if (tmr_expired) begin
                    if (pend_q) begin
                        state_d   = ST_SETUP;
                        tmr_ld    = 1'b1;
                        tmr_val   = V_SETUP;
                        shift_clr = 1'b1;
                        bits_d    = '0;
                        pend_d    = 1'b0;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bits_q  <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            bits_q  <= bits_d;
            pend_q  <= pend_d;
        end
    end

    // R6: asleep is only reached through a full sleep hold
    p_sleep_via_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ASLEEP && $past(state_q) != ST_ASLEEP) |-> ($past(state_q) == ST_SLP_HOLD));

    // R8: a read frame starts only from rest or straight after a wake hold
    p_frame_entry_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETUP && $past(state_q) != ST_SETUP)
            |-> ($past(state_q) == ST_IDLE || $past(state_q) == ST_WAKE_HOLD));

    // R2: the frame closes only after WORD_W high phases
    p_bit_total_r2: assert property (@(posedge clk) disable iff (rst)
        word_done |-> (bits_q == LAST_BIT));

endmodule

// File: rtl/adc_rd_ctrl.sv
`timescale 1ns/1ps
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int unsigned CLK_MHZ      = 200,
    parameter int unsigned WORD_W       = 16,
    parameter int unsigned SCLK_HALF_NS = 250,
    parameter int unsigned SETUP_NS     = 200,
    parameter int unsigned GAP_NS       = 150,
    parameter int unsigned SLEEP_NS     = 2_000_000,
    parameter int unsigned WAKE_NS      = 10_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_read,
    input  logic              enter_sleep,
    input  logic              wake,
    input  logic              adc_ser_dat,
    output logic              adc_sel_n,
    output logic              adc_ser_clk,
    output logic              busy,
    output logic [WORD_W-1:0] data_out,
    output logic              data_valid
);
    localparam int unsigned N_SETUP = ns_to_cycles(SETUP_NS, CLK_MHZ);
    localparam int unsigned N_HALF  = ns_to_cycles(SCLK_HALF_NS, CLK_MHZ);
    localparam int unsigned N_GAP   = ns_to_cycles(GAP_NS, CLK_MHZ);
    localparam int unsigned N_SLEEP = ns_to_cycles(SLEEP_NS, CLK_MHZ);
    localparam int unsigned N_WAKE  = ns_to_cycles(WAKE_NS, CLK_MHZ);
    localparam int unsigned N_MAX   =
        max_u(max_u(max_u(N_SETUP, N_HALF), max_u(N_GAP, N_SLEEP)), N_WAKE);
    localparam int TW = $clog2(N_MAX + 1);

    seq_state_e    state;
    line_ctrl_t    lines;
    logic          tmr_ld, tmr_expired;
    logic [TW-1:0] tmr_val;
    logic          shift_clr, shift_en, word_done;

    adc_phase_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .ld      (tmr_ld),
        .ld_val  (tmr_val),
        .expired (tmr_expired)
    );

    adc_seq_fsm #(
        .WORD_W  (WORD_W),
        .N_SETUP (N_SETUP),
        .N_HALF  (N_HALF),
        .N_GAP   (N_GAP),
        .N_SLEEP (N_SLEEP),
        .N_WAKE  (N_WAKE),
        .TW      (TW)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cmd_read    (start_read),
        .cmd_sleep   (enter_sleep),
        .cmd_wake    (wake),
        .tmr_expired (tmr_expired),
        .tmr_ld      (tmr_ld),
        .tmr_val     (tmr_val),
        .shift_clr   (shift_clr),
        .shift_en    (shift_en),
        .word_done   (word_done),
        .state       (state)
    );

    adc_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .clr        (shift_clr),
        .shift_en   (shift_en),
        .bit_in     (adc_ser_dat),
        .word_done  (word_done),
        .word_out   (data_out),
        .word_valid (data_valid)
    );

    assign lines       = drive_lines(state);
    assign adc_ser_clk = lines.ser_clk;
    assign adc_sel_n   = lines.sel_n;
    assign busy        = lines.busy;

    // run-length observers for the line timing properties
    logic          clk_d;
    logic [TW-1:0] lvl_run_q;
    logic [TW-1:0] sel_run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_d     <= 1'b0;
            lvl_run_q <= '0;
            sel_run_q <= '0;
        end else begin
            clk_d <= adc_ser_clk;
            if (adc_ser_clk != clk_d)  lvl_run_q <= TW'(1);
            else if (lvl_run_q != '1)  lvl_run_q <= lvl_run_q + 1'b1;
            if (adc_sel_n)             sel_run_q <= '0;
            else if (sel_run_q != '1)  sel_run_q <= sel_run_q + 1'b1;
        end
    end

    // R2: high phase within a frame lasts at least N_HALF cycles
    p_high_width_r2: assert property (@(posedge clk) disable iff (rst)
        ($fell(adc_ser_clk) && !adc_sel_n) |-> (lvl_run_q >= TW'(N_HALF)));

    // R2: every rising clock edge in a frame comes after the select setup time
    p_setup_time_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(adc_ser_clk) && !adc_sel_n) |-> (sel_run_q >= TW'(N_SETUP)));

    // R4: strobe only with select released and clock low
    p_valid_released_r4: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> (adc_sel_n && !adc_ser_clk && busy));

    // R2: an accepted read is busy in the next cycle
    p_read_accepts_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_read) |=> busy);

    // R10: sleep command while asleep leaves the block at rest
    p_sleep_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && adc_ser_clk && enter_sleep && !start_read && !wake) |=> (!busy && adc_ser_clk));

endmodule

// File: tb/tb_adc_rd_ctrl.sv
`timescale 1ns/1ps
module tb_adc_rd_ctrl;
    localparam int W       = 16;
    localparam int MHZ     = 200;
    localparam int HALF_NS = 250;
    localparam int SET_NS  = 200;
    localparam int GAP_NS  = 150;
    localparam int SLP_NS  = 20_000;
    localparam int WAK_NS  = 2_000;

    function automatic int cyc(input int ns);
        int c;
        c = (ns * MHZ + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_SETUP = (SET_NS * MHZ + 999) / 1000;
    localparam int E_HALF  = (HALF_NS * MHZ + 999) / 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_read = 1'b0, enter_sleep = 1'b0, wake = 1'b0;
    logic adc_ser_dat = 1'b0;
    logic adc_sel_n, adc_ser_clk, busy, data_valid;
    logic [W-1:0] data_out;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] tx_word = '0;
    int  tx_ptr = W - 1;
    logic prev_clk_line = 1'b0;
    bit asleep = 1'b0;

    always #2.5 clk = ~clk;

    adc_rd_ctrl #(
        .CLK_MHZ(MHZ), .WORD_W(W), .SCLK_HALF_NS(HALF_NS), .SETUP_NS(SET_NS),
        .GAP_NS(GAP_NS), .SLEEP_NS(SLP_NS), .WAKE_NS(WAK_NS)
    ) dut (
        .clk(clk), .rst(rst), .start_read(start_read), .enter_sleep(enter_sleep),
        .wake(wake), .adc_ser_dat(adc_ser_dat), .adc_sel_n(adc_sel_n),
        .adc_ser_clk(adc_ser_clk), .busy(busy), .data_out(data_out),
        .data_valid(data_valid)
    );

    // converter model: first bit on select fall, next bit after each falling clock
    always @(negedge clk) begin
        if (adc_sel_n) tx_ptr = W - 1;
        else if (prev_clk_line && !adc_ser_clk) tx_ptr = tx_ptr - 1;
        prev_clk_line = adc_ser_clk;
        adc_ser_dat = (tx_ptr >= 0) ? tx_word[tx_ptr] : 1'b0;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_read(input logic [W-1:0] word, input bit noise, input bit with_sleep);
        int pre = 0, setup = 0, rises = 0, hi_bad = 0, lo_bad = 0;
        int vcnt = 0, gap = 0, run = 0, guard = 0, pre_hi = 0;
        logic [W-1:0] vdata = '0;
        logic vsel = 1'b0, prev_s = 1'b0, prev_sel = 1'b1;
        bit was_asleep;
        was_asleep = asleep;
        tx_word = word;
        @(negedge clk);
        start_read = 1'b1;
        enter_sleep = with_sleep;
        @(negedge clk);
        start_read = 1'b0;
        enter_sleep = 1'b0;
        while (busy && guard < 20000) begin
            guard++;
            if (noise) begin
                start_read  = 1'($urandom % 2);
                enter_sleep = 1'($urandom % 2);
                wake        = 1'($urandom % 2);
            end
            if (adc_sel_n) begin
                if (rises == 0) begin
                    pre++;
                    if (adc_ser_clk) pre_hi++;
                end else begin
                    if (!prev_sel && run != E_HALF) lo_bad++;
                    gap++;
                end
            end else begin
                if (prev_sel) begin
                    run = 1;
                    prev_s = adc_ser_clk;
                end else if (adc_ser_clk == prev_s) begin
                    run++;
                end else begin
                    if (adc_ser_clk) begin
                        rises++;
                        if (rises == 1) setup = run;
                        else if (run != E_HALF) lo_bad++;
                    end else if (run != E_HALF) begin
                        hi_bad++;
                    end
                    run = 1;
                    prev_s = adc_ser_clk;
                end
            end
            if (data_valid) begin
                vcnt++;
                vdata = data_out;
                vsel = adc_sel_n;
            end
            prev_sel = adc_sel_n;
            @(negedge clk);
        end
        start_read = 1'b0;
        enter_sleep = 1'b0;
        wake = 1'b0;
        asleep = 1'b0;
        check(pre == (was_asleep ? cyc(WAK_NS) : 0), was_asleep ? "R8" : "R2",
              "cycles before select falls", pre, was_asleep ? cyc(WAK_NS) : 0);
        check(pre_hi == 0, "R7", "clock high during wake hold", pre_hi, 0);
        check(setup == E_SETUP, "R2", "select-to-first-rise cycles", setup, E_SETUP);
        check(rises == W, "R2", "rising edges per frame", rises, W);
        check(hi_bad == 0 && lo_bad == 0, "R2", "phases not N_HALF long", hi_bad + lo_bad, 0);
        check(vcnt == 1, "R4", "valid strobe cycles", vcnt, 1);
        check(vsel == 1'b1, "R4", "select level at strobe", vsel, 1);
        check(vdata == word, "R3", "received word", vdata, word);
        check(gap == cyc(GAP_NS), "R5", "busy gap after select rises", gap, cyc(GAP_NS));
        check(!adc_ser_clk && adc_sel_n, "R5", "lines at rest after frame", adc_ser_clk, 0);
        if (noise || with_sleep) begin
            @(negedge clk);
            check(!busy && !adc_ser_clk, noise ? "R9" : "R11",
                  "busy after frame with extra commands", busy, 0);
        end
        check(data_out == word, "R4", "word held after strobe", data_out, word);
    endtask

    task automatic do_sleep();
        int n = 0, bad = 0;
        @(negedge clk);
        enter_sleep = 1'b1;
        @(negedge clk);
        enter_sleep = 1'b0;
        while (busy && n < 100000) begin
            n++;
            if (!adc_ser_clk || !adc_sel_n) bad++;
            @(negedge clk);
        end
        asleep = 1'b1;
        check(n == cyc(SLP_NS), "R6", "sleep hold cycles", n, cyc(SLP_NS));
        check(bad == 0, "R6", "cycles with clock low or select low in hold", bad, 0);
        repeat (3) @(negedge clk);
        check(adc_ser_clk && !busy, "R6", "clock high at rest asleep", adc_ser_clk, 1);
    endtask

    task automatic do_wake();
        int n = 0, bad = 0;
        @(negedge clk);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        while (busy && n < 100000) begin
            n++;
            if (adc_ser_clk || !adc_sel_n) bad++;
            @(negedge clk);
        end
        asleep = 1'b0;
        check(n == cyc(WAK_NS), "R7", "wake hold cycles", n, cyc(WAK_NS));
        check(bad == 0, "R7", "cycles with clock high in wake hold", bad, 0);
        check(!adc_ser_clk && !busy, "R7", "clock low at rest awake", adc_ser_clk, 0);
    endtask

    // R10: a command with no meaning in the current rest state
    task automatic do_ignored();
        logic lvl;
        lvl = adc_ser_clk;
        @(negedge clk);
        if (asleep) enter_sleep = 1'b1;
        else        wake = 1'b1;
        @(negedge clk);
        enter_sleep = 1'b0;
        wake = 1'b0;
        check(!busy, "R10", "busy after ignored command", busy, 0);
        @(negedge clk);
        check(adc_ser_clk == lvl && adc_sel_n, "R10", "clock level after ignored command",
              adc_ser_clk, lvl);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed_0a1c);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(adc_sel_n && !adc_ser_clk && !busy && !data_valid && data_out == '0,
              "R1", "outputs during reset", data_out, 0);
        rst = 1'b0;
        @(negedge clk);
        check(adc_sel_n && !adc_ser_clk && !busy && !data_valid, "R1",
              "outputs after reset", busy, 0);

        do_read(16'h8001, 1'b0, 1'b0);
        do_read(16'hffff, 1'b0, 1'b0);
        do_read(16'h0000, 1'b0, 1'b0);
        do_read(16'ha5c3, 1'b0, 1'b1);     // R11 read beats sleep
        do_read(16'h3c5a, 1'b1, 1'b0);     // R9 commands during busy
        do_ignored();                      // R10 wake while awake
        do_sleep();
        do_ignored();                      // R10 sleep while asleep
        do_wake();
        do_sleep();
        do_read(16'h1234, 1'b0, 1'b0);     // R8 read while asleep
        do_sleep();
        do_read(16'hbeef, 1'b0, 1'b1);     // R11 and R8 together

        for (int i = 0; i < 16; i++) begin
            int op;
            op = $urandom % 5;
            if (op <= 2)      do_read(W'($urandom), 1'(op == 1), 1'(op == 2));
            else if (op == 3) begin
                if (asleep) do_wake();
                else        do_sleep();
            end else          do_ignored();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule